// File: doc/BRIEF.md
# Key Lifetime Auto-Zeroise Controller

This block guards a secret key held in a bank of 32-bit key-word registers. Software programs the key, the cipher configuration and a lifetime, then issues an init command. The block forwards a start pulse to the cipher engine and waits for the engine's init-done pulse. When that pulse arrives it marks the key as loaded and starts a countdown. The countdown is made of a down-counter and a 4-bit prescaler, so one lifetime unit is 16 clock cycles.

When the countdown runs out, or when software issues a forced zeroise, the block spends one cycle in a wipe state. During that cycle it drives a clear strobe to the key words and to the engine's expanded-key memory, and the loaded flag drops. While the key is loaded, a next command or a rewrite of the lifetime register counts as a keep-alive. It reloads the countdown to its full value. A lifetime of zero turns automatic expiry off.

The controller state machine has five states:
- EMPTY: no key is loaded.
- INIT_REQ: the one-cycle start pulse to the engine.
- INIT_WAIT: waiting for init-done.
- LOADED: the key is usable and the countdown is running.
- WIPE: the one-cycle clear.

Its transitions are:
- zeroise: any state except WIPE goes to WIPE.
- init: EMPTY, INIT_WAIT and LOADED go to INIT_REQ.
- request issued: INIT_REQ goes to INIT_WAIT.
- init done: INIT_WAIT goes to LOADED.
- keep-alive: LOADED stays in LOADED.
- expiry: LOADED goes to WIPE.
- wipe done: WIPE goes to EMPTY.

Top module: `key_life_guard`

## Requirements
- R1: After reset, the loaded flag is 0, every key word reads 0, the lifetime register reads 0 and all strobes are low. Status reads {loaded, valid, ready} in bits 2, 1 and 0, where bits 1 and 0 follow the engine inputs.
- R2: The register map is as follows.
  - Address 0x08 is the control register. Bit 0 is init, bit 1 is next and bit 2 is zeroise. The bits are self-clearing and it always reads 0.
  - Address 0x09 is status.
  - Address 0x0a is config. Bit 0 is the encrypt/decrypt select and bit 1 the key length. Both bits read back and drive their outputs.
  - Address 0x0b is the lifetime.
  - Addresses 0x10 to 0x17 are key words 0 to 7, readable and writable.
- R3: A write of init drives eng_init_o high for exactly the one cycle after the write edge. The loaded flag rises in the cycle after an edge at which eng_init_done_i is high in INIT_WAIT.
- R4: With a lifetime T other than 0, loaded stays high for exactly 16*T cycles after the init-done edge. In the next cycle key_clear_o is high and loaded is low.
- R5: With a lifetime of 0, the key never expires.
- R6: A control write with bit 2 set makes loaded low and key_clear_o high in the cycle after the write, whatever time remains. Zeroise takes priority over init in the same write, and no start pulse follows.
- R7: A next command while loaded pulses eng_next_o for one cycle and restarts the full 16*T lifetime from that write edge. A next command while not loaded gives no eng_next_o pulse.
- R8: A lifetime write while loaded restarts the countdown from the newly written value. Writing 0 while loaded stops expiry.
- R9: key_clear_o is high for exactly one cycle per wipe. Afterwards every key word reads 0 and loaded stays low until a new init completes.
- R10: An eng_init_done_i pulse outside INIT_WAIT is ignored and loaded stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Register access select |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational during a read |
| eng_ready_i | input | 1 | Engine ready, shown in status bit 0 |
| eng_valid_i | input | 1 | Engine result valid, shown in status bit 1 |
| eng_init_done_i | input | 1 | One-cycle pulse when key expansion is complete |
| eng_init_o | output | 1 | One-cycle start pulse for key expansion |
| eng_next_o | output | 1 | One-cycle next-operation pulse |
| key_clear_o | output | 1 | One-cycle clear strobe for the expanded-key memory |
| cfg_encdec_o | output | 1 | Encrypt/decrypt select |
| cfg_keylen_o | output | 1 | Key length select |
| key_o | output | 256 | Key words, word 0 in the lowest bits |

## Verification
The lifetime is tried with directed values 0, 2, 3 and 6 and with random lifetimes of 1 to 4 units. Each random run samples the loaded flag at a random cycle on either side of the 16*T boundary, which tells an off-by-one in the prescaler or unit counter apart from a correct count.

Keep-alive is tried in two ways, by a next command and by a lifetime rewrite, both at a point where the original countdown would already have expired. This shows whether the reload restarts from the write edge or from the old count.

Forced zeroise is tried in three cases:
- against a running key,
- against a never-expiring key,
- combined with init in one write, which shows the command priority.

Stray init-done and next pulses in EMPTY show that these events only act in their own states.

// File: rtl/kz_pkg.sv
package kz_pkg;
    localparam logic [7:0] ADR_CTRL    = 8'h08;
    localparam logic [7:0] ADR_STATUS  = 8'h09;
    localparam logic [7:0] ADR_CONFIG  = 8'h0a;
    localparam logic [7:0] ADR_LIFE    = 8'h0b;
    localparam logic [7:0] ADR_KEYBASE = 8'h10;

    localparam int BIT_INIT = 0;
    localparam int BIT_NEXT = 1;
    localparam int BIT_ZERO = 2;

    typedef enum logic [2:0] {
        ST_EMPTY     = 3'd0,
        ST_INIT_REQ  = 3'd1,
        ST_INIT_WAIT = 3'd2,
        ST_LOADED    = 3'd3,
        ST_WIPE      = 3'd4
    } kz_state_t;
endpackage

// File: rtl/kz_regs.sv
module kz_regs #(
    parameter int NKW    = 8,
    parameter int DATA_W = 32,
    parameter int LIFE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [7:0]            addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  wipe_i,
    output logic [NKW*DATA_W-1:0] key_flat_o,
    output logic [1:0]            cfg_o,
    output logic [LIFE_W-1:0]     life_o
);
    import kz_pkg::*;

    for (genvar g = 0; g < NKW; g++) begin : g_key
        localparam logic [7:0] WADR = 8'(int'(ADR_KEYBASE) + g);
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          word_q <= '0;
            else if (wipe_i)                     word_q <= '0;
            else if (wr_en_i && addr_i == WADR)  word_q <= wdata_i;
        end
        assign key_flat_o[g*DATA_W +: DATA_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o  <= '0;
            life_o <= '0;
        end else if (wr_en_i) begin
            if (addr_i == ADR_CONFIG) cfg_o  <= wdata_i[1:0];
            if (addr_i == ADR_LIFE)   life_o <= wdata_i[LIFE_W-1:0];
        end
    end

    // R9: a wipe strobe leaves every key word at zero
    a_r9_key_words_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> (key_flat_o == '0));
endmodule

// File: rtl/kz_life_timer.sv
module kz_life_timer #(
    parameter int LIFE_W = 16,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LIFE_W-1:0] load_val_i,
    input  logic              stop_i,
    output logic              expire_o,
    output logic              running_o
);
    localparam logic [PRE_W-1:0]  PRE_TOP = {PRE_W{1'b1}};
    localparam logic [LIFE_W-1:0] ONE     = LIFE_W'(1);

    logic [LIFE_W-1:0] units_q;
    logic [PRE_W-1:0]  pre_q;
    logic              run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            units_q <= '0;
            pre_q   <= '0;
            run_q   <= 1'b0;
        end else if (stop_i) begin
            run_q <= 1'b0;
        end else if (load_i) begin
            units_q <= load_val_i;
            pre_q   <= PRE_TOP;
            run_q   <= (load_val_i != '0);
        end else if (run_q) begin
            if (pre_q == '0) begin
                if (units_q == ONE) begin
                    run_q <= 1'b0;
                end else begin
                    units_q <= units_q - ONE;
                    pre_q   <= PRE_TOP;
                end
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

    assign expire_o  = run_q && (pre_q == '0) && (units_q == ONE);
    assign running_o = run_q;

    // R5: a zero lifetime never starts the countdown
    a_r5_zero_life_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !stop_i && load_val_i == '0) |=> !running_o);
    // R4: a running countdown only stops through expiry, stop or reload
    a_r4_runs_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !load_i && !stop_i && !expire_o) |=> running_o);
endmodule

// File: rtl/kz_fsm.sv
module kz_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_init_i,
    input  logic cmd_next_i,
    input  logic cmd_zero_i,
    input  logic life_wr_i,
    input  logic init_done_i,
    input  logic expire_i,
    output logic timer_load_o,
    output logic timer_stop_o,
    output logic eng_init_o,
    output logic eng_next_o,
    output logic key_clear_o,
    output logic loaded_o
);
    import kz_pkg::*;

    kz_state_t state_q, state_d;
    logic      keep_alive;
    logic      next_q;

    assign keep_alive = cmd_next_i || life_wr_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (cmd_zero_i)      state_d = ST_WIPE;
                else if (cmd_init_i) state_d = ST_INIT_REQ;
            end
            ST_INIT_REQ: begin
                if (cmd_zero_i)      state_d = ST_WIPE;
                else if (cmd_init_i) state_d = ST_INIT_REQ;
                else                 state_d = ST_INIT_WAIT;
            end
            ST_INIT_WAIT: begin
                if (cmd_zero_i)       state_d = ST_WIPE;
                else if (cmd_init_i)  state_d = ST_INIT_REQ;
                else if (init_done_i) state_d = ST_LOADED;
            end
            ST_LOADED: begin
                if (cmd_zero_i)      state_d = ST_WIPE;
                else if (cmd_init_i) state_d = ST_INIT_REQ;
                else if (keep_alive) state_d = ST_LOADED;
                else if (expire_i)   state_d = ST_WIPE;
            end
            ST_WIPE: state_d = ST_EMPTY;
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) next_q <= 1'b0;
        else        next_q <= cmd_next_i && (state_q == ST_LOADED) && (state_d == ST_LOADED);
    end

    assign timer_load_o = (state_d == ST_LOADED) &&
                          ((state_q == ST_INIT_WAIT) || keep_alive);
    assign timer_stop_o = (state_d != ST_LOADED);
    assign eng_init_o   = (state_q == ST_INIT_REQ);
    assign eng_next_o   = next_q;
    assign key_clear_o  = (state_q == ST_WIPE);
    assign loaded_o     = (state_q == ST_LOADED);

    // R9: the wipe lasts a single cycle
    a_r9_wipe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WIPE) |=> (state_q == ST_EMPTY));
    // R6: zeroise beats every other command
    a_r6_zero_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_zero_i && state_q != ST_WIPE) |=> (state_q == ST_WIPE));
    // R10: loaded is only entered from the waiting state on init-done
    a_r10_loaded_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loaded_o) |-> $past(state_q == ST_INIT_WAIT && init_done_i));
    // R3: the start pulse lasts one cycle unless init is re-issued
    a_r3_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_init_o && !cmd_init_i) |=> !eng_init_o);
endmodule

// File: rtl/key_life_guard.sv
module key_life_guard #(
    parameter int NKW    = 8,
    parameter int LIFE_W = 16,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [7:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              eng_ready_i,
    input  logic              eng_valid_i,
    input  logic              eng_init_done_i,
    output logic              eng_init_o,
    output logic              eng_next_o,
    output logic              key_clear_o,
    output logic              cfg_encdec_o,
    output logic              cfg_keylen_o,
    output logic [NKW*32-1:0] key_o
);
    import kz_pkg::*;

    localparam int DATA_W = 32;

    logic              wr, ctrl_wr, life_wr;
    logic              cmd_init, cmd_next, cmd_zero;
    logic [1:0]        cfg;
    logic [LIFE_W-1:0] life, load_val;
    logic              t_load, t_stop, t_expire, t_run;
    logic              loaded;

    assign wr       = cs_i && we_i;
    assign ctrl_wr  = wr && (addr_i == ADR_CTRL);
    assign life_wr  = wr && (addr_i == ADR_LIFE);
    assign cmd_init = ctrl_wr && wdata_i[BIT_INIT];
    assign cmd_next = ctrl_wr && wdata_i[BIT_NEXT];
    assign cmd_zero = ctrl_wr && wdata_i[BIT_ZERO];
    assign load_val = life_wr ? wdata_i[LIFE_W-1:0] : life;

    kz_regs #(.NKW(NKW), .DATA_W(DATA_W), .LIFE_W(LIFE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr), .addr_i(addr_i), .wdata_i(wdata_i),
        .wipe_i(key_clear_o), .key_flat_o(key_o), .cfg_o(cfg), .life_o(life)
    );

    kz_life_timer #(.LIFE_W(LIFE_W), .PRE_W(PRE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(t_load), .load_val_i(load_val),
        .stop_i(t_stop), .expire_o(t_expire), .running_o(t_run)
    );

    kz_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_init_i(cmd_init), .cmd_next_i(cmd_next),
        .cmd_zero_i(cmd_zero), .life_wr_i(life_wr), .init_done_i(eng_init_done_i),
        .expire_i(t_expire), .timer_load_o(t_load), .timer_stop_o(t_stop),
        .eng_init_o(eng_init_o), .eng_next_o(eng_next_o),
        .key_clear_o(key_clear_o), .loaded_o(loaded)
    );

    assign cfg_encdec_o = cfg[0];
    assign cfg_keylen_o = cfg[1];

    always_comb begin
        rdata_o = '0;
        if (cs_i && !we_i) begin
            if (addr_i == ADR_STATUS)      rdata_o = {29'd0, loaded, eng_valid_i, eng_ready_i};
            else if (addr_i == ADR_CONFIG) rdata_o = {30'd0, cfg};
            else if (addr_i == ADR_LIFE)   rdata_o = 32'(life);
            for (int i = 0; i < NKW; i++) begin
                if (addr_i == 8'(int'(ADR_KEYBASE) + i)) rdata_o = key_o[i*DATA_W +: DATA_W];
            end
        end
    end

    // R6: a forced zeroise reaches the clear strobe on the next cycle
    a_r6_zero_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_zero && !key_clear_o) |=> (key_clear_o && !loaded));
    // R4: the countdown only runs while a key is loaded
    a_r4_timer_with_key: assert property (@(posedge clk) disable iff (!rst_n)
        t_run |-> loaded);
endmodule

// File: tb/key_life_guard_tb_top.sv
module key_life_guard_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_i = 1'b0, we_i = 1'b0;
    logic [7:0]   addr_i = '0;
    logic [31:0]  wdata_i = '0;
    logic [31:0]  rdata_o;
    logic         eng_ready_i = 1'b1, eng_valid_i = 1'b0, eng_init_done_i = 1'b0;
    logic         eng_init_o, eng_next_o, key_clear_o, cfg_encdec_o, cfg_keylen_o;
    logic [255:0] key_o;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    key_life_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .eng_ready_i(eng_ready_i),
        .eng_valid_i(eng_valid_i), .eng_init_done_i(eng_init_done_i),
        .eng_init_o(eng_init_o), .eng_next_o(eng_next_o), .key_clear_o(key_clear_o),
        .cfg_encdec_o(cfg_encdec_o), .cfg_keylen_o(cfg_keylen_o), .key_o(key_o)
    );

    function automatic logic [31:0] exp_loaded(int t, int w);
        return (t == 0 || w < 16 * t) ? 32'd1 : 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        cs_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd_now(logic [7:0] a, output logic [31:0] d);
        cs_i = 1'b1; we_i = 1'b0; addr_i = a;
        #0.5;
        d = rdata_o;
        cs_i = 1'b0;
    endtask

    task automatic loaded_now(output logic [31:0] l);
        logic [31:0] s;
        rd_now(8'h09, s);
        l = {31'd0, s[2]};
    endtask

    // returns at the negedge of cycle 0 after the init-done edge
    task automatic do_init();
        wr(8'h08, 32'h1);
        check("R3 init pulse high", {31'd0, eng_init_o}, 32'd1);
        @(negedge clk);
        check("R3 init pulse ends", {31'd0, eng_init_o}, 32'd0);
        eng_init_done_i = 1'b1;
        @(negedge clk);
        eng_init_done_i = 1'b0;
    endtask

    task automatic zeroise();
        wr(8'h08, 32'h4);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done_flag) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_now(8'h09, v); check("R1 status after reset", v, 32'h1);
        rd_now(8'h13, v); check("R1 key word after reset", v, 32'h0);
        rd_now(8'h0b, v); check("R1 lifetime after reset", v, 32'h0);
        check("R1 strobes low", {29'd0, eng_init_o, eng_next_o, key_clear_o}, 32'd0);

        // R2 register map
        for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i), 32'hA5A5_0000 + 32'(i * 17));
        rd_now(8'h15, v); check("R2 key word 5", v, 32'hA5A5_0000 + 32'd85);
        check("R2 key_o word 7", key_o[255:224], 32'hA5A5_0000 + 32'd119);
        wr(8'h0a, 32'h2);
        rd_now(8'h0a, v); check("R2 config readback", v, 32'h2);
        check("R2 config outputs", {30'd0, cfg_keylen_o, cfg_encdec_o}, 32'h2);
        eng_valid_i = 1'b1;
        rd_now(8'h09, v); check("R2 status valid bit", v, 32'h3);
        eng_valid_i = 1'b0;
        wr(8'h08, 32'h2);
        rd_now(8'h08, v); check("R2 control reads zero", v, 32'h0);
        check("R7 no next while empty", {31'd0, eng_next_o}, 32'd0);

        // R3 / R4 auto expiry with lifetime 6
        wr(8'h0b, 32'd6);
        rd_now(8'h0b, v); check("R2 lifetime readback", v, 32'd6);
        do_init();
        loaded_now(v); check("R3 loaded after done", v, 32'd1);
        repeat (16 * 6 - 1) @(negedge clk);
        loaded_now(v); check("R4 loaded in last cycle", v, 32'd1);
        @(negedge clk);
        loaded_now(v); check("R4 loaded low on expiry", v, 32'd0);
        check("R4 clear strobe on expiry", {31'd0, key_clear_o}, 32'd1);
        @(negedge clk);
        check("R9 clear strobe single", {31'd0, key_clear_o}, 32'd0);
        rd_now(8'h12, v); check("R9 key word zero after wipe", v, 32'h0);
        check("R9 key_o zero", (key_o == '0) ? 32'd1 : 32'd0, 32'd1);
        repeat (5) @(negedge clk);
        loaded_now(v); check("R9 stays unloaded", v, 32'd0);

        // R5 lifetime zero, then R6 forced zeroise
        wr(8'h10, 32'h1234_5678);
        wr(8'h0b, 32'd0);
        do_init();
        repeat (300) @(negedge clk);
        loaded_now(v); check("R5 zero lifetime never expires", v, 32'd1);
        wr(8'h08, 32'h4);
        loaded_now(v); check("R6 forced zeroise drops loaded", v, 32'd0);
        check("R6 forced zeroise strobe", {31'd0, key_clear_o}, 32'd1);
        @(negedge clk);
        rd_now(8'h10, v); check("R6 key cleared by force", v, 32'h0);

        // R7 keep-alive by next
        wr(8'h0b, 32'd2);
        do_init();
        repeat (20) @(negedge clk);
        wr(8'h08, 32'h2);
        check("R7 next pulse", {31'd0, eng_next_o}, 32'd1);
        @(negedge clk);
        check("R7 next pulse single", {31'd0, eng_next_o}, 32'd0);
        repeat (30) @(negedge clk);
        loaded_now(v); check("R7 reloaded lifetime last cycle", v, 32'd1);
        @(negedge clk);
        loaded_now(v); check("R7 reloaded lifetime expires", v, 32'd0);
        repeat (2) @(negedge clk);

        // R8 keep-alive by lifetime rewrite
        do_init();
        repeat (20) @(negedge clk);
        wr(8'h0b, 32'd3);
        repeat (47) @(negedge clk);
        loaded_now(v); check("R8 rewrite reload last cycle", v, 32'd1);
        @(negedge clk);
        loaded_now(v); check("R8 rewrite reload expires", v, 32'd0);
        repeat (2) @(negedge clk);
        wr(8'h0b, 32'd2);
        do_init();
        repeat (10) @(negedge clk);
        wr(8'h0b, 32'd0);
        repeat (100) @(negedge clk);
        loaded_now(v); check("R8 rewrite to zero disables", v, 32'd1);
        zeroise();

        // R6 zeroise beats init in one write
        wr(8'h0b, 32'd0);
        do_init();
        wr(8'h08, 32'h5);
        check("R6 zero+init strobes clear", {31'd0, key_clear_o}, 32'd1);
        @(negedge clk);
        check("R6 zero+init no start pulse", {31'd0, eng_init_o}, 32'd0);

        // R10 stray init-done
        @(negedge clk);
        eng_init_done_i = 1'b1;
        @(negedge clk);
        eng_init_done_i = 1'b0;
        loaded_now(v); check("R10 stray done ignored", v, 32'd0);

        // R4 random lifetimes around the boundary
        for (int it = 0; it < 16; it++) begin
            int t, w;
            t = 1 + int'($urandom % 4);
            w = int'($urandom % (16 * t + 8));
            wr(8'h0b, 32'(t));
            do_init();
            repeat (w) @(negedge clk);
            loaded_now(v); check("R4 random lifetime sample", v, exp_loaded(t, w));
            zeroise();
        end

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule